// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries short command words between two ports that run on unrelated clocks, alongside a separate data queue. Each direction has its own word register: port A posts into the A-to-B mailbox and port B collects it, and port B posts into the B-to-A mailbox and port A collects it. A port talks to a mailbox instead of the queue when its mailbox-select pin is high during an access. The queue itself is not part of this block. Only its output word comes in, so that each port's read data can be steered between the queue and the mailbox.

Each mailbox has an active-low full flag in the writer's clock domain and a ready indication in the reader's clock domain. A post drives the writer's flag low and locks the word until the other side has collected it. The post and the collect events cross between domains as toggles passed through two-flop synchronizers. Because of this, the writer's flag stays low until the collect has been carried back, and the reader's ready goes high only after the post has been carried over. The ports are control pins, sampled on every edge, with no handshake. A post while the flag is low, and a collect while ready is low, are silently dropped.

Top module: `mbx_pair`

## Requirements
- R1: While rst_n is low, and right after it rises, both full flags (a_mbf_n, b_mbf_n) are 1, both ready outputs are 0 and both mailbox words are zero.
- R2: On a clk_a rising edge where a_cs, a_wr, a_en and a_mbx are all 1 and a_mbf_n is 1, a_din is stored as the A-to-B word and a_mbf_n reads 0 after that edge.
- R3: On a clk_b rising edge where b_cs, b_wr, b_en and b_mbx are all 1 and b_mbf_n is 1, b_din is stored as the B-to-A word and b_mbf_n reads 0 after that edge.
- R4: A post attempted while the writer's full flag is 0 leaves the stored word unchanged.
- R5: An access with any of cs, en or mbx at 0 neither stores a word nor collects one.
- R6: The reader's ready output (b_rdy for the A-to-B word, a_rdy for the B-to-A word) rises on the second reader-clock rising edge after the edge that moves the posting toggle.
- R7: A collect is an access with cs=1, wr=0, en=1 and mbx=1 while ready is 1. It clears ready after that edge, and the writer's flag returns to 1 on the second writer-clock edge after the toggle moves.
- R8: A collect attempted while ready is 0 has no effect on any flag.
- R9: Read data is combinational: b_dout equals the A-to-B word when b_mbx=1 and b_fifo_q otherwise. a_dout equals the B-to-A word when a_mbx=1 and a_fifo_q otherwise.
- R10: A collected word stays visible on the reader's dout with mbx=1 until the next accepted post replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs | input | 1 | Port A select, active high |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A mailbox select (1 = mailbox, 0 = queue) |
| a_din | input | 36 | Port A write word |
| a_fifo_q | input | 36 | Queue output word presented to port A |
| a_dout | output | 36 | Port A read data |
| a_mbf_n | output | 1 | A-to-B mailbox full flag, active low, clk_a domain |
| a_rdy | output | 1 | B-to-A word waiting, clk_a domain |
| b_cs | input | 1 | Port B select, active high |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_en | input | 1 | Port B access enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write word |
| b_fifo_q | input | 36 | Queue output word presented to port B |
| b_dout | output | 36 | Port B read data |
| b_mbf_n | output | 1 | B-to-A mailbox full flag, active low, clk_b domain |
| b_rdy | output | 1 | A-to-B word waiting, clk_b domain |

## Verification
The bench targets several corner cases of the handoff.

- **Overwrite lock.** A second post arrives while the flag is still low. A design without the lock would corrupt the word before it is collected.
- **Collect while nothing is waiting.** A collect arrives while ready is low. A design that counts it would release the writer's flag early and lose the next word.
- **Synchronizer depth.** The two-edge latency in each direction is compared on every clock. A design that skipped a synchronizer stage would show ready or the flag one edge early, and one with an extra stage would show it one edge late.
- **Read mux and word retention.** The read mux is checked with random queue words under both select values, and after collection the word must still be readable. This catches a design that swapped the mux legs or cleared the word on collect.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic cs;
    logic wr;
    logic en;
    logic mbx;
  } port_ctl_t;

  function automatic logic is_post(input port_ctl_t c);
    return c.cs & c.wr & c.en & c.mbx;
  endfunction

  function automatic logic is_collect(input port_ctl_t c);
    return c.cs & ~c.wr & c.en & c.mbx;
  endfunction

endpackage

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf <= '0;
    else        shf <= {shf[STAGES-2:0], d};
  end

  assign q = shf[STAGES-1];
endmodule

// File: rtl/mbx_lane.sv
module mbx_lane #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk_w,
  input  logic         clk_r,
  input  logic         rst_n,
  input  logic         post,
  input  logic [W-1:0] post_data,
  input  logic         collect,
  output logic         full_n,
  output logic         ready,
  output logic [W-1:0] word_q
);
  logic post_tgl, take_tgl;
  logic post_tgl_r, take_tgl_w;
  logic post_ok, take_ok;

  // writer domain
  mbx_sync2 #(.STAGES(STAGES)) u_back (
    .clk(clk_w), .rst_n(rst_n), .d(take_tgl), .q(take_tgl_w));

  assign full_n  = (post_tgl == take_tgl_w);
  assign post_ok = post & full_n;

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      post_tgl <= 1'b0;
      word_q   <= '0;
    end else if (post_ok) begin
      post_tgl <= ~post_tgl;
      word_q   <= post_data;
    end
  end

  // reader domain
  mbx_sync2 #(.STAGES(STAGES)) u_fwd (
    .clk(clk_r), .rst_n(rst_n), .d(post_tgl), .q(post_tgl_r));

  assign ready   = (post_tgl_r != take_tgl);
  assign take_ok = collect & ready;

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)       take_tgl <= 1'b0;
    else if (take_ok) take_tgl <= ~take_tgl;
  end

  // R2 R3
  set_flag_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
    (post && full_n) |=> !full_n);

  // R4
  hold_when_full_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
    (post && !full_n) |=> $stable(word_q));

  // R7 R8
  ready_fall_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
    $fell(ready) |-> $past(collect));

  // R10
  word_locked_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
    (ready && !collect) |=> $stable(word_q));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mbx,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         a_mbf_n,
  output logic         a_rdy,
  input  logic         b_cs,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mbx,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_mbf_n,
  output logic         b_rdy
);
  localparam int NP = 2;  // index 0 = port A, 1 = port B

  port_ctl_t      ctl   [NP];
  logic           clk_p [NP];
  logic [W-1:0]   din_p [NP];
  logic [W-1:0]   word  [NP];  // word[i] written by port i
  logic           full_n[NP];
  logic           rdy   [NP];  // rdy[i] seen by the reader of lane i

  assign ctl[0]   = '{cs: a_cs, wr: a_wr, en: a_en, mbx: a_mbx};
  assign ctl[1]   = '{cs: b_cs, wr: b_wr, en: b_en, mbx: b_mbx};
  assign clk_p[0] = clk_a;
  assign clk_p[1] = clk_b;
  assign din_p[0] = a_din;
  assign din_p[1] = b_din;

  for (genvar i = 0; i < NP; i++) begin : g_lane
    localparam int RD = NP - 1 - i;
    mbx_lane #(.W(W), .STAGES(STAGES)) u_lane (
      .clk_w    (clk_p[i]),
      .clk_r    (clk_p[RD]),
      .rst_n    (rst_n),
      .post     (is_post(ctl[i])),
      .post_data(din_p[i]),
      .collect  (is_collect(ctl[RD])),
      .full_n   (full_n[i]),
      .ready    (rdy[i]),
      .word_q   (word[i])
    );
  end

  assign a_mbf_n = full_n[0];
  assign b_mbf_n = full_n[1];
  assign b_rdy   = rdy[0];
  assign a_rdy   = rdy[1];
  assign a_dout  = a_mbx ? word[1] : a_fifo_q;
  assign b_dout  = b_mbx ? word[0] : b_fifo_q;

  // R9
  a_mux_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_mbx) |-> (a_dout == a_fifo_q));
endmodule

// File: tb/tb_mbx_pair.sv
module tb_mbx_pair;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mbx = 0;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mbx = 0;
  logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_mbf_n, a_rdy, b_mbf_n, b_rdy;

  int compared = 0, mismatched = 0;

  always #5 clk_a = ~clk_a;
  initial begin #3; forever #7 clk_b = ~clk_b; end

  mbx_pair dut (.*);

  // reference model: counts of accepted posts/collects, delayed views
  int w1, r1, w2, r2;
  int r1_a0, r1_a1, w2_a0, w2_a1;
  int w1_b0, w1_b1, r2_b0, r2_b1;
  logic [W-1:0] m1, m2;

  always @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      w1 <= 0; r2 <= 0; m1 <= '0;
      r1_a0 <= 0; r1_a1 <= 0; w2_a0 <= 0; w2_a1 <= 0;
    end else begin
      if (a_cs && a_wr && a_en && a_mbx && (w1 == r1_a1)) begin
        m1 <= a_din; w1 <= w1 + 1;
      end
      if (a_cs && !a_wr && a_en && a_mbx && (w2_a1 != r2)) r2 <= r2 + 1;
      r1_a0 <= r1; r1_a1 <= r1_a0;
      w2_a0 <= w2; w2_a1 <= w2_a0;
    end
  end

  always @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      w2 <= 0; r1 <= 0; m2 <= '0;
      w1_b0 <= 0; w1_b1 <= 0; r2_b0 <= 0; r2_b1 <= 0;
    end else begin
      if (b_cs && b_wr && b_en && b_mbx && (w2 == r2_b1)) begin
        m2 <= b_din; w2 <= w2 + 1;
      end
      if (b_cs && !b_wr && b_en && b_mbx && (w1_b1 != r1)) r1 <= r1 + 1;
      w1_b0 <= w1; w1_b1 <= w1_b0;
      r2_b0 <= r2; r2_b1 <= r2_b0;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t got=%h exp=%h", req, $time, got, exp);
    end
  endtask

  bit running = 0;
  always @(negedge clk_a) if (running) begin
    chk("R2 R7 a_mbf_n", W'(a_mbf_n), W'(w1 == r1_a1));
    chk("R6 R8 a_rdy", W'(a_rdy), W'(w2_a1 != r2));
    chk("R9 R4 R5 R10 a_dout", a_dout, a_mbx ? m2 : a_fifo_q);
  end
  always @(negedge clk_b) if (running) begin
    chk("R3 R7 b_mbf_n", W'(b_mbf_n), W'(w2 == r2_b1));
    chk("R6 R8 b_rdy", W'(b_rdy), W'(w1_b1 != r1));
    chk("R9 R4 R5 R10 b_dout", b_dout, b_mbx ? m1 : b_fifo_q);
  end

  task automatic drive_a(input bit cs, wr, en, mbx, input logic [W-1:0] d);
    @(posedge clk_a); #1;
    a_cs = cs; a_wr = wr; a_en = en; a_mbx = mbx; a_din = d;
    a_fifo_q = {$urandom, 4'h5};
  endtask
  task automatic drive_b(input bit cs, wr, en, mbx, input logic [W-1:0] d);
    @(posedge clk_b); #1;
    b_cs = cs; b_wr = wr; b_en = en; b_mbx = mbx; b_din = d;
    b_fifo_q = {$urandom, 4'hA};
  endtask

  task automatic port_a;
    // R5: partial selects, R2 post, R4 overwrite attempt, R8 early collect
    drive_a(1, 1, 0, 1, 36'h111111111);
    drive_a(1, 1, 1, 0, 36'h222222222);
    drive_a(0, 1, 1, 1, 36'h333333333);
    drive_a(1, 0, 1, 1, '0);
    drive_a(1, 1, 1, 1, 36'hABCDEF012);
    drive_a(1, 1, 1, 1, 36'h0DEADBEEF);
    for (int k = 0; k < 20; k++) drive_a(0, 0, 0, 1, '0);
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive_a(r[0] | r[1], r[2], r[3] | r[0], ($urandom % 4) != 0, {$urandom, 4'($urandom)});
    end
    drive_a(0, 0, 0, 1, '0);
  endtask

  task automatic port_b;
    drive_b(0, 0, 0, 1, '0);
    drive_b(1, 0, 1, 1, '0); // R8 before anything posted
    for (int k = 0; k < 12; k++) drive_b(0, 0, 0, 1, '0);
    drive_b(1, 0, 1, 1, '0); // R7 collect
    for (int k = 0; k < 10; k++) drive_b(0, 0, 0, 1, '0); // R10 word held
    drive_b(1, 1, 1, 1, 36'h123456789); // R3
    for (int k = 0; k < 2100; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive_b(r[0] | r[1], r[2], r[3] | r[1], ($urandom % 4) != 0, {$urandom, 4'($urandom)});
    end
  endtask

  initial begin
    fork
      begin
        running = 1;
        #56;
        // R1: reset values held through reset
        chk("R1 a_mbf_n", W'(a_mbf_n), W'(1));
        chk("R1 b_mbf_n", W'(b_mbf_n), W'(1));
        chk("R1 a_rdy", W'(a_rdy), W'(0));
        chk("R1 b_rdy", W'(b_rdy), W'(0));
        a_mbx = 1; b_mbx = 1; #1;
        chk("R1 a_dout", a_dout, '0);
        chk("R1 b_dout", b_dout, '0);
        rst_n = 1;
        fork port_a(); port_b(); join
        repeat (10) @(posedge clk_a);
      end
      begin
        #400000;
        mismatched++;
        $display("FAIL watchdog expired t=%0t", $time);
      end
    join_any
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule